// File: doc/BRIEF.md
# Burst Address Sequencer with Byte-Lane Write Decode

This block is the synchronous front end of a small burst-capable memory. A load strobe captures a starting word address. An advance strobe then steps a two-bit beat count, and the two low address bits follow the beat count in one of two orders. The order is picked by a mode input that can change at run time. In linear order the low bits count upward and wrap modulo four. In interleaved order the low bits are the starting value XOR the beat count. The bits above the low two stay fixed for the whole burst. After four advances the count is back at zero, so the fifth beat presents the starting address again.

On every cycle the block also decodes a global write, a byte write and one active-low enable per byte lane into a per-lane write strobe. That strobe updates a register-based array at the current burst address. When neither write is asserted the cycle is a read: every lane drives data, and an output-enable flag goes high. A sleep input puts the block in standby. In standby there are no writes, no reads, and no change to the address state.

At integration, tie the mode input high and the sleep input low when the system does not drive them. These are the inactive defaults. The `WIDE_BUS` parameter selects four byte lanes or two.

Top module: `burst_sram_front`

## Requirements
- R1: After reset the current address is zero, the beat count is zero and every array word reads as zero.
- R2: A load strobe while awake puts the sampled start address on `curAddr` in the next cycle and clears the beat count. A load takes priority over an advance in the same cycle.
- R3: With `interleaveSel` low, the low two address bits equal (start + beats) modulo 4. Starting at 1, for example, gives 1,2,3,0.
- R4: With `interleaveSel` high, the low two address bits equal start XOR beats. Starting at 1, for example, gives 1,0,3,2.
- R5: After four advances the beat count wraps, so the fifth beat of a burst shows the starting address again.
- R6: Without a load, `curAddr[ADDR_W-1:2]` does not change, whatever the advance strobe does.
- R7: With `globalWrN` low and not asleep, every lane strobe is high, whatever `byteWrN` and `laneEnN` are. Lane k holds `wrData[8k+7:8k]`.
- R8: With `globalWrN` high and `byteWrN` low, the strobe of lane k is high exactly when `laneEnN[k]` is low. Any combination of lanes is allowed.
- R9: With both write inputs high and not asleep, `rdOe` is high, no strobe is set, and `rdData` shows every lane of the word at `curAddr`, whatever `laneEnN` is.
- R10: In any write cycle `rdOe` is low and `rdData` is zero.
- R11: While `sleepReq` is high, `standby` is high, no strobe is set, `rdOe` is low, and load and advance have no effect on the address state or the array.
- R12: With `WIDE_BUS` = 0 only lanes 0 and 1 exist. They behave exactly as the lower two lanes of the wide build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Standby request, active high (tie low when unused) |
| interleaveSel | input | 1 | Burst order: 1 interleaved, 0 linear (tie high when unused) |
| loadReq | input | 1 | Capture `baseAddr` as the new burst start |
| advanceReq | input | 1 | Step the beat count |
| baseAddr | input | ADDR_W | Burst starting address |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrN | input | 1 | Write enabled lanes, active low |
| laneEnN | input | LANES | Per-lane enable for byte writes, active low |
| wrData | input | LANES*8 | Write data, lane k in bits 8k+7:8k |
| curAddr | output | ADDR_W | Current burst address |
| laneStrobe | output | LANES | Per-lane write strobe this cycle |
| rdData | output | LANES*8 | Read data, zero unless `rdOe` |
| rdOe | output | 1 | Output enable, high on read cycles |
| standby | output | 1 | Block is in standby |

## Verification
The bench builds two copies side by side. One has `WIDE_BUS` = 1 and `ADDR_W` = 4, the other has `WIDE_BUS` = 0 and `ADDR_W` = 4, and both get the same stimulus. The 4-bit address gives a 16-word array that the bench fills completely. It is also small enough that all four start values in both orders, and the wrap on the fifth beat, run in full at an upper address that is not zero. Running the narrow copy beside the wide one shows that dropping the upper lanes leaves the lower lanes unchanged. All sixteen enable patterns in byte-write mode are covered.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int MAX_LANES = 4;
  localparam int BYTE_W    = 8;

  typedef struct packed {
    logic                 loadEn;
    logic                 stepEn;
    logic                 readOe;
    logic [MAX_LANES-1:0] writeLanes;
  } burstStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic             loadReq,
  input  logic             advanceReq,
  input  logic             globalWrN,
  input  logic             byteWrN,
  input  logic [LANES-1:0] laneEnN,
  output burstStrobes_t    strobes
);
  logic             awake;
  logic             globalWrite;
  logic             byteWrite;
  logic             readCycle;
  logic [LANES-1:0] laneMask;
  logic [MAX_LANES-1:0] laneVec;

  always_comb begin
    awake       = !sleepReq;
    globalWrite = awake && !globalWrN;
    byteWrite   = awake && globalWrN && !byteWrN;
    readCycle   = awake && globalWrN && byteWrN;
    if (globalWrite)    laneMask = '1;
    else if (byteWrite) laneMask = ~laneEnN;
    else                laneMask = '0;
  end

  generate
    for (genvar g = 0; g < MAX_LANES; g++) begin : gLane
      if (g < LANES) begin : gLive
        assign laneVec[g] = laneMask[g];
      end else begin : gAbsent
        assign laneVec[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    strobes.loadEn     = awake && loadReq;
    strobes.stepEn     = awake && advanceReq;
    strobes.readOe     = readCycle;
    strobes.writeLanes = laneVec;
  end

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |-> (strobes.writeLanes == '0 && !strobes.readOe)); // R11
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |-> (!strobes.loadEn && !strobes.stepEn)); // R11
  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepReq && !globalWrN) |-> ($countones(strobes.writeLanes) == LANES)); // R7
  AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readOe |-> (strobes.writeLanes == '0)); // R10
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  burstStrobes_t           strobes,
  input  logic [ADDR_W-1:0]       baseAddr,
  input  logic                    interleaveSel,
  input  logic [LANES*BYTE_W-1:0] wrData,
  output logic [ADDR_W-1:0]       curAddr,
  output logic [LANES*BYTE_W-1:0] rdData
);
  localparam int UPPER_W = ADDR_W - 2;
  localparam int DEPTH   = 1 << ADDR_W;

  logic [UPPER_W-1:0] upperReg;
  logic [1:0]         startReg;
  logic [1:0]         beatReg;
  logic [1:0]         lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperReg <= '0;
      startReg <= '0;
      beatReg  <= '0;
    end else if (strobes.loadEn) begin
      upperReg <= baseAddr[ADDR_W-1:2];
      startReg <= baseAddr[1:0];
      beatReg  <= '0;
    end else if (strobes.stepEn) begin
      beatReg  <= beatReg + 2'd1;
    end
  end

  always_comb begin
    if (interleaveSel) lowBits = startReg ^ beatReg;
    else               lowBits = startReg + beatReg;
  end

  assign curAddr = {upperReg, lowBits};

  generate
    for (genvar g = 0; g < LANES; g++) begin : gMem
      logic [BYTE_W-1:0] laneMem [DEPTH];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < DEPTH; i++) laneMem[i] <= '0;
        end else if (strobes.writeLanes[g]) begin
          laneMem[curAddr] <= wrData[g*BYTE_W +: BYTE_W];
        end
      end

      assign rdData[g*BYTE_W +: BYTE_W] = strobes.readOe ? laneMem[curAddr] : '0;
    end
  endgenerate

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn |=> (curAddr == $past(baseAddr))); // R2
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> $stable(curAddr[ADDR_W-1:2])); // R6
  AST_WRAP_START: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepEn && !strobes.loadEn && beatReg == 2'd3)
      |=> (curAddr == {upperReg, startReg})); // R5
  AST_SILENT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.readOe |-> (rdData == '0)); // R10
endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front
  import burst_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter bit WIDE_BUS = 1'b1,
  parameter int LANES    = WIDE_BUS ? 4 : 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sleepReq,
  input  logic                    interleaveSel,
  input  logic                    loadReq,
  input  logic                    advanceReq,
  input  logic [ADDR_W-1:0]       baseAddr,
  input  logic                    globalWrN,
  input  logic                    byteWrN,
  input  logic [LANES-1:0]        laneEnN,
  input  logic [LANES*BYTE_W-1:0] wrData,
  output logic [ADDR_W-1:0]       curAddr,
  output logic [LANES-1:0]        laneStrobe,
  output logic [LANES*BYTE_W-1:0] rdData,
  output logic                    rdOe,
  output logic                    standby
);
  burstStrobes_t strobes;

  burst_ctrl #(.LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sleepReq   (sleepReq),
    .loadReq    (loadReq),
    .advanceReq (advanceReq),
    .globalWrN  (globalWrN),
    .byteWrN    (byteWrN),
    .laneEnN    (laneEnN),
    .strobes    (strobes)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .LANES(LANES)) u_path (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .baseAddr      (baseAddr),
    .interleaveSel (interleaveSel),
    .wrData        (wrData),
    .curAddr       (curAddr),
    .rdData        (rdData)
  );

  assign laneStrobe = strobes.writeLanes[LANES-1:0];
  assign rdOe       = strobes.readOe;
  assign standby    = sleepReq;
endmodule

// File: tb/burst_sram_front_tb.sv
module burst_sram_front_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sleepReq = 1'b0;
  logic        interleaveSel = 1'b1;
  logic        loadReq = 1'b0;
  logic        advanceReq = 1'b0;
  logic [3:0]  baseAddr = '0;
  logic        globalWrN = 1'b1;
  logic        byteWrN = 1'b1;
  logic [3:0]  laneEnN = '1;
  logic [31:0] wrData = '0;

  logic [3:0]  curAddr, nCurAddr;
  logic [3:0]  laneStrobe;
  logic [1:0]  nLaneStrobe;
  logic [31:0] rdData;
  logic [15:0] nRdData;
  logic        rdOe, nRdOe, standby, nStandby;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int mUpper = 0, mStart = 0, mBeat = 0;
  logic [7:0] mMem [16][4];

  always #5 clk = ~clk;

  burst_sram_front #(.ADDR_W(4), .WIDE_BUS(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .interleaveSel(interleaveSel),
    .loadReq(loadReq), .advanceReq(advanceReq), .baseAddr(baseAddr),
    .globalWrN(globalWrN), .byteWrN(byteWrN), .laneEnN(laneEnN), .wrData(wrData),
    .curAddr(curAddr), .laneStrobe(laneStrobe), .rdData(rdData), .rdOe(rdOe),
    .standby(standby));

  burst_sram_front #(.ADDR_W(4), .WIDE_BUS(1'b0)) u_dutNarrow (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .interleaveSel(interleaveSel),
    .loadReq(loadReq), .advanceReq(advanceReq), .baseAddr(baseAddr),
    .globalWrN(globalWrN), .byteWrN(byteWrN), .laneEnN(laneEnN[1:0]),
    .wrData(wrData[15:0]), .curAddr(nCurAddr), .laneStrobe(nLaneStrobe),
    .rdData(nRdData), .rdOe(nRdOe), .standby(nStandby));

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int modelAddr();
    int low;
    if (interleaveSel) low = mStart ^ mBeat;
    else               low = (mStart + mBeat) & 3;
    return mUpper * 4 + low;
  endfunction

  function automatic logic [3:0] modelStrobe();
    if (sleepReq)        return 4'b0000;
    if (!globalWrN)      return 4'b1111;
    if (!byteWrN)        return ~laneEnN;
    return 4'b0000;
  endfunction

  task automatic cyc(input string tag, input bit ld, input bit adv, input logic [3:0] base,
                     input bit mode, input bit slp, input bit gw, input bit bw,
                     input logic [3:0] en, input logic [31:0] wd);
    int a;
    logic [3:0] st;
    logic oe;
    logic [31:0] rd;
    @(negedge clk);
    loadReq = ld; advanceReq = adv; baseAddr = base; interleaveSel = mode;
    sleepReq = slp; globalWrN = gw; byteWrN = bw; laneEnN = en; wrData = wd;
    #4;
    a  = modelAddr();
    st = modelStrobe();
    oe = !slp && gw && bw;
    rd = oe ? {mMem[a][3], mMem[a][2], mMem[a][1], mMem[a][0]} : 32'h0;
    chk(tag, "curAddr", 32'(curAddr), 32'(a));
    chk(tag, "laneStrobe", 32'(laneStrobe), 32'(st));
    chk(tag, "rdOe", 32'(rdOe), 32'(oe));
    chk(tag, "rdData", rdData, rd);
    chk(tag, "standby", 32'(standby), 32'(slp));
    chk("R12", "narrow curAddr", 32'(nCurAddr), 32'(a));
    chk("R12", "narrow laneStrobe", 32'(nLaneStrobe), 32'(st[1:0]));
    chk("R12", "narrow rdData", 32'(nRdData), rd & 32'h0000_ffff);
    chk("R12", "narrow rdOe", 32'(nRdOe), 32'(oe));
    @(posedge clk);
    for (int l = 0; l < 4; l++) if (st[l]) mMem[a][l] = wd[l*8 +: 8];
    if (!slp) begin
      if (ld) begin
        mUpper = int'(base) >> 2; mStart = int'(base) & 3; mBeat = 0;
      end else if (adv) begin
        mBeat = (mBeat + 1) & 3;
      end
    end
  endtask

  task automatic rd(input string tag, input bit mode, input logic [3:0] en);
    cyc(tag, 1'b0, 1'b0, 4'h0, mode, 1'b0, 1'b1, 1'b1, en, 32'hdead_beef);
  endtask

  task automatic burst(input string tag, input bit mode, input logic [3:0] base);
    cyc("R2", 1'b1, 1'b0, base, mode, 1'b0, 1'b1, 1'b1, 4'hf, 32'h0);
    for (int k = 0; k < 5; k++)
      cyc(tag, 1'b0, 1'b1, 4'h0, mode, 1'b0, 1'b1, 1'b1, 4'hf, 32'h0);
    rd("R5", mode, 4'hf);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) for (int l = 0; l < 4; l++) mMem[i][l] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    rd("R1", 1'b1, 4'hf);
    rd("R1", 1'b0, 4'h0);
    // R7: fill every word with a global write, enables deliberately mixed
    for (int a = 0; a < 16; a++) begin
      cyc("R2", 1'b1, 1'b0, 4'(a), 1'b1, 1'b0, 1'b1, 1'b1, 4'hf, 32'h0);
      cyc("R7", 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'(a & 1), 4'(a),
          {8'(a + 8'h40), 8'(a + 8'h30), 8'(a + 8'h20), 8'(a + 8'h10)});
      rd("R9", 1'b1, 4'(15 - a));
    end
    // R3 linear and R4 interleaved bursts from every start, upper bits nonzero
    for (int s = 0; s < 4; s++) burst("R3", 1'b0, 4'(8 + s));
    for (int s = 0; s < 4; s++) burst("R4", 1'b1, 4'(4 + s));
    // R6: upper bits held while advancing from the top word
    cyc("R2", 1'b1, 1'b0, 4'hf, 1'b1, 1'b0, 1'b1, 1'b1, 4'hf, 32'h0);
    for (int k = 0; k < 6; k++)
      cyc("R6", 1'b0, 1'b1, 4'h0, 1'(k & 1), 1'b0, 1'b1, 1'b1, 4'hf, 32'h0);
    // R2: load wins over advance
    cyc("R2", 1'b1, 1'b1, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1, 4'hf, 32'h0);
    rd("R2", 1'b0, 4'hf);
    // R8: all enable patterns in byte-write mode, each followed by a read
    cyc("R2", 1'b1, 1'b0, 4'h5, 1'b1, 1'b0, 1'b1, 1'b1, 4'hf, 32'h0);
    for (int p = 0; p < 16; p++) begin
      cyc("R8", 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 4'(p), $urandom);
      rd("R9", 1'b1, 4'(p));
    end
    // R10: writes while the burst advances
    for (int k = 0; k < 4; k++)
      cyc("R10", 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'(k & 1), 1'b0, 4'(k * 3), $urandom);
    for (int k = 0; k < 4; k++) rd("R9", 1'b0, 4'h0);
    // R11: standby ignores load, advance and writes
    cyc("R11", 1'b1, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 32'h1234_5678);
    cyc("R11", 1'b0, 1'b1, 4'h0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 32'h9abc_def0);
    cyc("R11", 1'b1, 1'b1, 4'h9, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 32'h5555_aaaa);
    cyc("R11", 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hf, 32'h0);
    rd("R11", 1'b1, 4'hf);
    rd("R11", 1'b0, 4'hf);
    // full array readback
    for (int a = 0; a < 16; a++) begin
      cyc("R2", 1'b1, 1'b0, 4'(a), 1'b0, 1'b0, 1'b1, 1'b1, 4'hf, 32'h0);
      rd("R9", 1'b0, 4'(a));
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule